// File: doc/BRIEF.md
# USB Device Interrupt Status Controller

This block collects the interrupt causes of a USB device controller into one 32-bit read-only status word and drives a single interrupt line. Bus-level events from the protocol engine arrive as one-cycle pulses and are held in sticky flags until software clears them. Software clears a flag by writing a one to the matching bit of a separate clear register. The same status word also carries live summary bits for each endpoint and each DMA channel, and a live bus-speed indicator.

An enable register picks which causes may raise the interrupt line. The wake-up flag is held on an always-running clock, so a wake event is caught even while the main controller clock is stopped. Software reaches the block through a simple register port with strobes, an address and data. The register offsets are 0x00 for the status word, 0x04 for the enable register and 0x08 for the clear register.

Top module: `usbd_irq_status`

## Requirements
- R1: After reset the status word reads 0x0000_0000. A write to offset 0x00 changes neither the status word nor the enable register.
- R2: Status bits have these positions: bit 0 speed, bit 1 suspend, bit 2 micro-frame start, bit 3 frame start, bit 4 end of bus reset, bit 5 wake-up, bit 6 end of resume, bit 7 upstream resume, bits 8..23 endpoints 0..15, and bits 25..31 DMA channels 1..7 (`dma_src[0]` maps to bit 25). Bit 24 reads zero. Read data is registered: it appears one cycle after `reg_rd` and is zero in cycles with no read.
- R3: A pulse on an event input (suspend, micro-frame, frame, end of reset, end of resume, upstream resume) sets its status bit on the next clock. The bit stays set until a write to offset 0x08 has a one in that bit position. Zeros written there leave bits unchanged.
- R4: An endpoint bit reads one only while `ep_src[i]` is high and enable bit 8+i is set. It drops when the source drops.
- R5: While `usb_bus_rst` is high, all endpoint bits 8..23 read zero.
- R6: A DMA bit 25+j reads one only while `dma_src[j]` is high and enable bit 25+j is set.
- R7: Bit 0 follows `hs_mode` (one for high speed, zero for full speed) and never asserts `irq`.
- R8: The wake-up flag is set by `wake_evt` on `aon_clk` and cleared by writing a one to bit 5 of offset 0x08. With both clocks at the same rate, the set shows in the status word within 3 main-clock cycles and the clear within 6.
- R9: `irq` is registered. It is high one cycle after any status bit in 1..31 is one together with its enable bit.
- R10: The enable register resets to zero, reads back what was written, and holds bits 0 and 24 at zero. Offset 0x08 and unmapped offsets read zero.
- R11: If an event pulse and a clear write for the same flag fall in the same cycle, the flag is set.
- R12: Frame and micro-frame pulses never coincide. Pulses on consecutive cycles set both flags independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main controller clock |
| rst | input | 1 | Synchronous active-high reset, main domain |
| aon_clk | input | 1 | Always-running clock for the wake-up flag |
| aon_rst | input | 1 | Synchronous active-high reset, always-on domain |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ev_suspend | input | 1 | Suspend-detected pulse |
| ev_usof | input | 1 | Micro-frame start pulse |
| ev_sof | input | 1 | Frame start pulse |
| ev_end_reset | input | 1 | End-of-bus-reset pulse |
| ev_end_resume | input | 1 | End-of-resume pulse |
| ev_up_resume | input | 1 | Upstream resume pulse |
| wake_evt | input | 1 | Wake-up pulse, `aon_clk` domain |
| hs_mode | input | 1 | High-speed indicator |
| usb_bus_rst | input | 1 | USB bus reset level |
| ep_src | input | NUM_EP | Endpoint interrupt source levels |
| dma_src | input | NUM_DMA | DMA channel interrupt source levels |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with its defaults: 16 endpoints, 7 DMA channels, 8-bit offsets and two-stage synchronizers. It drives one clock into both `clk` and `aon_clk`, so the wake-up path has a fixed latency that the reference model reproduces cycle by cycle. With every endpoint and DMA position present, the full enable mask 0xFEFF_FFFE can be checked. The top endpoint and DMA bits are exercised, and the wake flag's round trip through both synchronizers is compared on every clock alongside the register-port flags.

// File: rtl/usbd_irq_pkg.sv
package usbd_irq_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned B_SPEED  = 0;
  localparam int unsigned B_SUSP   = 1;
  localparam int unsigned B_USOF   = 2;
  localparam int unsigned B_SOF    = 3;
  localparam int unsigned B_ENDRST = 4;
  localparam int unsigned B_WAKE   = 5;
  localparam int unsigned B_ENDRSM = 6;
  localparam int unsigned B_UPRSM  = 7;
  localparam int unsigned EP_LSB   = 8;
  localparam int unsigned EP_MAX   = 16;
  localparam int unsigned DMA_LSB  = 25;
  localparam int unsigned DMA_MAX  = 7;
  localparam int unsigned N_STICKY = 6;

  typedef enum logic [1:0] {
    SEL_STATUS,
    SEL_ENABLE,
    SEL_CLEAR,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/usbd_sync_bits.sv
module usbd_sync_bits #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/usbd_evt_flags.sv
module usbd_evt_flags #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  for (genvar i = 0; i < W; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            flag_q[i] <= 1'b0;
      else if (set_i[i])  flag_q[i] <= 1'b1;   // set has priority over clear
      else if (clr_i[i])  flag_q[i] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/usbd_wake_flag.sv
module usbd_wake_flag #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic aon_clk,
  input  logic aon_rst,
  input  logic wake_i,
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  output logic flag_o
);
  logic clr_tog_q;
  logic tog_aon;
  logic tog_prev_q;
  logic clr_aon;
  logic flag_aon_q;

  // main domain: each clear request flips a toggle
  always_ff @(posedge clk) begin
    if (rst)        clr_tog_q <= 1'b0;
    else if (clr_i) clr_tog_q <= ~clr_tog_q;
  end

  usbd_sync_bits #(.STAGES(SYNC_STAGES), .W(1)) u_tog_sync (
    .clk (aon_clk),
    .rst (aon_rst),
    .d_i (clr_tog_q),
    .q_o (tog_aon)
  );

  always_ff @(posedge aon_clk) begin
    if (aon_rst) tog_prev_q <= 1'b0;
    else         tog_prev_q <= tog_aon;
  end

  assign clr_aon = tog_aon ^ tog_prev_q;

  // always-on set/clear flag, set wins
  always_ff @(posedge aon_clk) begin
    if (aon_rst)      flag_aon_q <= 1'b0;
    else if (wake_i)  flag_aon_q <= 1'b1;
    else if (clr_aon) flag_aon_q <= 1'b0;
  end

  usbd_sync_bits #(.STAGES(SYNC_STAGES), .W(1)) u_flag_sync (
    .clk (clk),
    .rst (rst),
    .d_i (flag_aon_q),
    .q_o (flag_o)
  );
endmodule

// File: rtl/usbd_live_summary.sv
module usbd_live_summary
  import usbd_irq_pkg::*;
#(
  parameter int unsigned NUM_EP  = 16,
  parameter int unsigned NUM_DMA = 7
) (
  input  logic [NUM_EP-1:0]  ep_src,
  input  logic [NUM_EP-1:0]  ep_en,
  input  logic [NUM_DMA-1:0] dma_src,
  input  logic [NUM_DMA-1:0] dma_en,
  input  logic               bus_rst,
  output logic [EP_MAX-1:0]  ep_bits,
  output logic [DMA_MAX-1:0] dma_bits
);
  for (genvar i = 0; i < EP_MAX; i++) begin : g_ep
    if (i < NUM_EP) begin : g_on
      assign ep_bits[i] = ep_src[i] & ep_en[i] & ~bus_rst;
    end else begin : g_off
      assign ep_bits[i] = 1'b0;
    end
  end

  for (genvar j = 0; j < DMA_MAX; j++) begin : g_dma
    if (j < NUM_DMA) begin : g_on
      assign dma_bits[j] = dma_src[j] & dma_en[j];
    end else begin : g_off
      assign dma_bits[j] = 1'b0;
    end
  end
endmodule

// File: rtl/usbd_irq_status.sv
module usbd_irq_status
  import usbd_irq_pkg::*;
#(
  parameter int unsigned      NUM_EP      = 16,
  parameter int unsigned      NUM_DMA     = 7,
  parameter int unsigned      ADDR_W      = 8,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 'h00,
  parameter logic [ADDR_W-1:0] OFS_ENABLE = 'h04,
  parameter logic [ADDR_W-1:0] OFS_CLEAR  = 'h08
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               aon_clk,
  input  logic               aon_rst,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic               ev_suspend,
  input  logic               ev_usof,
  input  logic               ev_sof,
  input  logic               ev_end_reset,
  input  logic               ev_end_resume,
  input  logic               ev_up_resume,
  input  logic               wake_evt,
  input  logic               hs_mode,
  input  logic               usb_bus_rst,
  input  logic [NUM_EP-1:0]  ep_src,
  input  logic [NUM_DMA-1:0] dma_src,
  output logic               irq
);
  function automatic logic [WORD_W-1:0] en_mask_f();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int b = B_SUSP; b <= B_UPRSM; b++) m[b] = 1'b1;
    for (int i = 0; i < NUM_EP; i++)  m[EP_LSB + i]  = 1'b1;
    for (int j = 0; j < NUM_DMA; j++) m[DMA_LSB + j] = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] EN_MASK = en_mask_f();

  reg_sel_e           sel;
  logic               wr_enable;
  logic               wr_clear;
  logic [WORD_W-1:0]  en_q;
  logic [WORD_W-1:0]  stat_word;
  logic [WORD_W-1:0]  rdata_q;
  logic               irq_q;
  logic [N_STICKY-1:0] st_set;
  logic [N_STICKY-1:0] st_clr;
  logic [N_STICKY-1:0] st_flag;
  logic               wake_flag;
  logic [EP_MAX-1:0]  ep_bits;
  logic [DMA_MAX-1:0] dma_bits;

  // address decode
  always_comb begin
    if      (reg_addr == OFS_STATUS) sel = SEL_STATUS;
    else if (reg_addr == OFS_ENABLE) sel = SEL_ENABLE;
    else if (reg_addr == OFS_CLEAR)  sel = SEL_CLEAR;
    else                             sel = SEL_NONE;
  end

  assign wr_enable = reg_wr && (sel == SEL_ENABLE);
  assign wr_clear  = reg_wr && (sel == SEL_CLEAR);

  // enable register
  always_ff @(posedge clk) begin
    if (rst)            en_q <= '0;
    else if (wr_enable) en_q <= reg_wdata & EN_MASK;
  end

  // sticky device events, packed order: susp, usof, sof, endrst, endrsm, uprsm
  assign st_set = {ev_up_resume, ev_end_resume, ev_end_reset, ev_sof, ev_usof, ev_suspend};
  assign st_clr = wr_clear ? {reg_wdata[B_UPRSM], reg_wdata[B_ENDRSM], reg_wdata[B_ENDRST],
                              reg_wdata[B_SOF], reg_wdata[B_USOF], reg_wdata[B_SUSP]}
                           : '0;

  usbd_evt_flags #(.W(N_STICKY)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (st_set),
    .clr_i  (st_clr),
    .flag_o (st_flag)
  );

  usbd_wake_flag #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
    .aon_clk (aon_clk),
    .aon_rst (aon_rst),
    .wake_i  (wake_evt),
    .clk     (clk),
    .rst     (rst),
    .clr_i   (wr_clear && reg_wdata[B_WAKE]),
    .flag_o  (wake_flag)
  );

  usbd_live_summary #(.NUM_EP(NUM_EP), .NUM_DMA(NUM_DMA)) u_live (
    .ep_src   (ep_src),
    .ep_en    (en_q[EP_LSB +: NUM_EP]),
    .dma_src  (dma_src),
    .dma_en   (en_q[DMA_LSB +: NUM_DMA]),
    .bus_rst  (usb_bus_rst),
    .ep_bits  (ep_bits),
    .dma_bits (dma_bits)
  );

  // status word assembly
  always_comb begin
    stat_word                        = '0;
    stat_word[B_SPEED]               = hs_mode;
    stat_word[B_SUSP]                = st_flag[0];
    stat_word[B_USOF]                = st_flag[1];
    stat_word[B_SOF]                 = st_flag[2];
    stat_word[B_ENDRST]              = st_flag[3];
    stat_word[B_WAKE]                = wake_flag;
    stat_word[B_ENDRSM]              = st_flag[4];
    stat_word[B_UPRSM]               = st_flag[5];
    stat_word[EP_LSB +: EP_MAX]      = ep_bits;
    stat_word[DMA_LSB +: DMA_MAX]    = dma_bits;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (sel)
        SEL_STATUS: rdata_q <= stat_word;
        SEL_ENABLE: rdata_q <= en_q;
        default:    rdata_q <= '0;
      endcase
    end else begin
      rdata_q <= '0;
    end
  end

  // registered interrupt line
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_word & en_q & EN_MASK);
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/usbd_irq_status_chk.sv
module usbd_irq_status_chk #(
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] OFS_STATUS = 'h00,
  parameter logic [ADDR_W-1:0] OFS_CLEAR  = 'h08
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [31:0]       reg_rdata,
  input logic              ev_sof,
  input logic              ev_usof,
  input logic              usb_bus_rst,
  input logic              irq,
  input logic [31:0]       stat_word,
  input logic [31:0]       en_q
);
  p_status_ro_r1: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == OFS_STATUS) |=> $stable(en_q));

  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == 32'h0));

  p_sof_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    (stat_word[3] && !(reg_wr && reg_addr == OFS_CLEAR && reg_wdata[3])) |=> stat_word[3]);

  p_busrst_ep_r5: assert property (@(posedge clk) disable iff (rst)
    usb_bus_rst |-> (stat_word[23:8] == 16'h0));

  p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
    ((stat_word & en_q) == 32'h0) |=> !irq);

  p_clear_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_CLEAR) |=> (reg_rdata == 32'h0));

  p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    ev_sof |=> stat_word[3]);

  p_frame_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(ev_sof && ev_usof));
endmodule

bind usbd_irq_status usbd_irq_status_chk #(
  .ADDR_W     (ADDR_W),
  .OFS_STATUS (OFS_STATUS),
  .OFS_CLEAR  (OFS_CLEAR)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_rd      (reg_rd),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .reg_rdata   (reg_rdata),
  .ev_sof      (ev_sof),
  .ev_usof     (ev_usof),
  .usb_bus_rst (usb_bus_rst),
  .irq         (irq),
  .stat_word   (stat_word),
  .en_q        (en_q)
);

// File: tb/tb_usbd_irq_status.sv
`timescale 1ns/1ps
module tb_usbd_irq_status;
  localparam logic [7:0] A_STAT = 8'h00;
  localparam logic [7:0] A_EN   = 8'h04;
  localparam logic [7:0] A_CLR  = 8'h08;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_rd = 0, reg_wr = 0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ev_suspend = 0, ev_usof = 0, ev_sof = 0, ev_end_reset = 0;
  logic        ev_end_resume = 0, ev_up_resume = 0, wake_evt = 0;
  logic        hs_mode = 0, usb_bus_rst = 0;
  logic [15:0] ep_src = '0;
  logic [6:0]  dma_src = '0;
  logic        irq;

  int unsigned n_chk = 0, n_fail = 0;
  bit started = 0, done = 0;

  always #4 clk = ~clk;  // 125 MHz

  usbd_irq_status dut (
    .clk(clk), .rst(rst), .aon_clk(clk), .aon_rst(rst),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_suspend(ev_suspend), .ev_usof(ev_usof), .ev_sof(ev_sof),
    .ev_end_reset(ev_end_reset), .ev_end_resume(ev_end_resume),
    .ev_up_resume(ev_up_resume), .wake_evt(wake_evt), .hs_mode(hs_mode),
    .usb_bus_rst(usb_bus_rst), .ep_src(ep_src), .dma_src(dma_src), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_flag;
  logic [31:0] m_en, m_rd;
  logic        m_irq, m_wake, m_d1, m_d2, m_d3, m_s1, m_s2;
  wire  [7:0]  ev_vec = {ev_up_resume, ev_end_resume, 1'b0, ev_end_reset,
                         ev_sof, ev_usof, ev_suspend, 1'b0};

  always @(posedge clk) begin
    logic [31:0] s;
    logic        clr_wr;
    started <= 1'b1;
    s = '0;
    s[0] = hs_mode;
    for (int b = 1; b < 8; b++) if (b != 5) s[b] = m_flag[b];
    s[5] = m_s2;
    for (int i = 0; i < 16; i++) s[8+i]  = ep_src[i] & m_en[8+i] & ~usb_bus_rst;
    for (int j = 0; j < 7; j++)  s[25+j] = dma_src[j] & m_en[25+j];
    clr_wr = reg_wr && reg_addr == A_CLR;
    if (rst) begin
      m_flag <= '0; m_en <= '0; m_rd <= '0; m_irq <= 0;
      m_wake <= 0; m_d1 <= 0; m_d2 <= 0; m_d3 <= 0; m_s1 <= 0; m_s2 <= 0;
    end else begin
      m_rd  <= !reg_rd ? 32'h0 : (reg_addr == A_STAT) ? s : (reg_addr == A_EN) ? m_en : 32'h0;
      m_irq <= |(s & m_en);
      for (int b = 1; b < 8; b++)
        if (b != 5) m_flag[b] <= ev_vec[b] | (m_flag[b] & ~(clr_wr & reg_wdata[b]));
      if (reg_wr && reg_addr == A_EN) m_en <= reg_wdata & 32'hFEFF_FFFE;
      m_wake <= wake_evt ? 1'b1 : (m_d3 ? 1'b0 : m_wake);
      m_d1 <= clr_wr & reg_wdata[5]; m_d2 <= m_d1; m_d3 <= m_d2;
      m_s1 <= m_wake; m_s2 <= m_s1;
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk("R9 irq per-cycle", {31'h0, irq}, {31'h0, m_irq});
      chk("R2 rdata per-cycle", reg_rdata, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    reg_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    idle(1);

    rd(A_STAT, v); chk("R1 status after reset", v, 32'h0);
    rd(A_EN, v);   chk("R10 enable after reset", v, 32'h0);
    chk("R9 irq after reset", {31'h0, irq}, 32'h0);

    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v);   chk("R10 enable mask readback", v, 32'hFEFF_FFFE);
    hs_mode = 1; idle(2);
    rd(A_STAT, v); chk("R7 speed bit high-speed", v, 32'h1);
    chk("R7 speed raises no irq", {31'h0, irq}, 32'h0);

    ev_sof = 1; @(negedge clk); ev_sof = 0; idle(1);
    rd(A_STAT, v); chk("R3 frame flag set", v, 32'h9);
    chk("R9 irq from enabled flag", {31'h0, irq}, 32'h1);
    idle(3);
    rd(A_STAT, v); chk("R3 frame flag sticky", v, 32'h9);
    wr(A_CLR, 32'h8); idle(1);
    rd(A_STAT, v); chk("R3 frame flag cleared", v, 32'h1);
    chk("R9 irq drops after clear", {31'h0, irq}, 32'h0);

    ev_suspend = 1; ev_end_resume = 1; @(negedge clk);
    ev_suspend = 0; ev_end_resume = 0;
    ev_end_reset = 1; @(negedge clk); ev_end_reset = 0;
    wr(A_CLR, 32'h2);
    rd(A_STAT, v); chk("R3 partial clear keeps others", v, 32'h51);
    wr(A_CLR, 32'h50);
    rd(A_STAT, v); chk("R3 remaining flags cleared", v, 32'h1);

    ev_usof = 1; reg_wr = 1; reg_addr = A_CLR; reg_wdata = 32'h4;
    @(negedge clk);
    ev_usof = 0; reg_wr = 0; reg_wdata = '0;
    rd(A_STAT, v); chk("R11 set wins over clear", v, 32'h5);
    wr(A_CLR, 32'h4);
    rd(A_STAT, v); chk("R11 later clear works", v, 32'h1);

    ev_sof = 1; @(negedge clk); ev_sof = 0;
    ev_usof = 1; @(negedge clk); ev_usof = 0;
    rd(A_STAT, v); chk("R12 both frame flags set", v, 32'hD);
    wr(A_CLR, 32'hFF);
    rd(A_STAT, v); chk("R12 frame flags cleared", v, 32'h1);

    wr(A_STAT, 32'hFFFF_FFFF);
    rd(A_STAT, v); chk("R1 status write ignored", v, 32'h1);
    rd(A_EN, v);   chk("R1 status write leaves enable", v, 32'hFEFF_FFFE);

    wr(A_EN, 32'h0); ep_src = 16'h0008; idle(1);
    rd(A_STAT, v); chk("R4 endpoint masked", v, 32'h1);
    wr(A_EN, 32'h0000_0800);
    rd(A_STAT, v); chk("R4 endpoint enabled", v, 32'h801);
    chk("R9 irq from endpoint", {31'h0, irq}, 32'h1);
    usb_bus_rst = 1; idle(1);
    rd(A_STAT, v); chk("R5 bus reset clears endpoints", v, 32'h1);
    usb_bus_rst = 0; ep_src = 16'h8000; wr(A_EN, 32'h0080_0000);
    rd(A_STAT, v); chk("R4 top endpoint bit 23", v, 32'h0080_0001);
    ep_src = 16'h0; idle(1);
    rd(A_STAT, v); chk("R4 endpoint drops with source", v, 32'h1);

    wr(A_EN, 32'h8200_0000); dma_src = 7'h01; idle(1);
    rd(A_STAT, v); chk("R6 dma channel 1 bit 25", v, 32'h0200_0001);
    dma_src = 7'h43; idle(1);
    rd(A_STAT, v); chk("R6 dma channel 7 bit 31, channel 2 masked", v, 32'h8200_0001);
    chk("R2 bit 24 reads zero", {31'h0, v[24]}, 32'h0);
    dma_src = 7'h0; idle(1);
    rd(A_STAT, v); chk("R6 dma drops with source", v, 32'h1);

    wr(A_EN, 32'h20);
    wake_evt = 1; @(negedge clk); wake_evt = 0; idle(4);
    rd(A_STAT, v); chk("R8 wake flag visible", v, 32'h21);
    chk("R9 irq from wake", {31'h0, irq}, 32'h1);
    wr(A_CLR, 32'h20); idle(6);
    rd(A_STAT, v); chk("R8 wake flag cleared", v, 32'h1);

    wr(A_CLR, 32'h0);
    rd(A_CLR, v);   chk("R10 clear register reads zero", v, 32'h0);
    rd(8'h0C, v);   chk("R10 unmapped offset reads zero", v, 32'h0);

    wr(A_EN, 32'h0);
    ev_up_resume = 1; @(negedge clk); ev_up_resume = 0; idle(1);
    rd(A_STAT, v); chk("R3 upstream resume flag", v, 32'h81);
    chk("R9 disabled flag gives no irq", {31'h0, irq}, 32'h0);
    wr(A_EN, 32'h80); idle(1);
    chk("R9 irq once enabled", {31'h0, irq}, 32'h1);

    idle(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule